// File: doc/BRIEF.md
# Staged-Update SPI Configuration Register Port

This block is a SPI mode 0 slave that gives a host access to a 12-bit configuration address space. Every frame opens with a 16-bit instruction shifted in MSB first. The instruction holds a direction flag, a byte count and a start address. One to three data bytes follow the instruction. Each byte of a burst addresses the next lower register.

General registers are double-buffered. A write changes only the shadow copy. The values on `active_regs` move only when the host commits them through the update register. Three control registers act as soon as they are written:
- Port configuration at 0x000. Bit 7 picks the serial output pin and bit 5 is the soft reset.
- Readback select at 0x004, bit 0.
- Update at 0x234, bit 0.

The SPI pins are resynchronised into `clk`. SCLK must therefore stay low and high for several `clk` periods each.

Frame FSM states:
- IDLE: chip select is inactive.
- INSTR: shifting in the instruction.
- WDATA: receiving write bytes.
- RDATA: returning read bytes.
- DONE: the byte count is used up, so further clocks are ignored.

Transitions:
- IDLE to INSTR when chip select goes active.
- INSTR to WDATA or RDATA on the 16th SCLK rise, chosen by bit 15.
- WDATA or RDATA to DONE on the last counted byte.
- Any state to IDLE when chip select goes inactive.

Top module: `cfg_spi_port`

## Requirements
- R1: The instruction is 16 bits, MSB first. Bit 15 = 1 means read and 0 means write. Bits 14:13 hold the byte count minus one, and code 3 is served as 3 bytes. Bits 11:0 hold the start address. Bit 12 is ignored.
- R2: Data bytes are shifted MSB first. The first data byte maps to the start address and each following byte to the next lower address.
- R3: A write to a general register (NUM_REGS registers from REG_BASE, default 0x010 to 0x017) changes only its shadow copy. `active_regs` (register k in bits 8k+7:8k) does not change.
- R4: Writing a byte with bit 0 = 1 to 0x234 copies every shadow register into `active_regs`. Writing it with bit 0 = 0 copies nothing. The bit self-clears, so a read of 0x234 returns 0x00.
- R5: Bit 0 of 0x004 selects the readback source: 1 returns the shadow copy and 0 returns the active copy. It reads back at bit 0 and takes effect at once.
- R6: A read returns exactly the counted number of bytes. `sdo_drive` or `dio_turn` is high only while those bytes are being returned, and `spi_miso` is 0 otherwise.
- R7: Bit 7 of 0x000 = 1 selects 4-wire mode, where `sdo_drive` is asserted during read data. Bit 7 = 0, the default, selects 3-wire mode, where `dio_turn` is asserted instead. A read of 0x000 returns bit 7.
- R8: Writing bit 5 = 1 to 0x000 returns every shadow, active and control register to its default of zero one clock later. The bit then clears itself.
- R9: Raising chip select in the middle of a byte discards that partial byte and changes no register. Bytes already completed in that frame keep their effect.
- R10: Reads of unimplemented addresses return 0x00, and writes to them change nothing.
- R11: After reset, `active_regs` is zero, neither driver enable is asserted, and the port is in 3-wire mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial read data, valid while a driver enable is high |
| sdo_drive | output | 1 | Enable for the dedicated output pin (4-wire read data) |
| dio_turn | output | 1 | Enable for turning the shared data line around (3-wire read data) |
| active_regs | output | NUM_REGS*8 | Committed register values, register k at bits 8k+7:8k |

## Verification
A corrupted shadow register is not visible on `active_regs` until the next commit. It only shows up at once when the host reads with readback select = 1, so the bench reads every register under both selects. A wrong address counter or byte index shows up in the byte order of a burst, or as a driver enable held one byte too long. Both are visible within the same frame. A pending update or soft reset that sticks would disturb `active_regs` on the cycle after it fires, and a later read of 0x234 or 0x000 would expose it.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] ADDR_PORTCFG = 12'h000;
    localparam logic [ADDR_W-1:0] ADDR_RBSEL   = 12'h004;
    localparam logic [ADDR_W-1:0] ADDR_UPDATE  = 12'h234;

    localparam int BIT_SDO_EN = 7;
    localparam int BIT_SRST   = 5;
    localparam int BIT_RBSEL  = 0;
    localparam int BIT_UPDATE = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INSTR,
        ST_WDATA,
        ST_RDATA,
        ST_DONE
    } frame_state_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic mosi_s
);
    logic [STAGES-1:0] sclk_q;
    logic [STAGES-1:0] cs_q;
    logic [STAGES-1:0] mosi_q;
    logic              sclk_prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sclk_q <= '0;
                    cs_q   <= '1;
                    mosi_q <= '0;
                end else begin
                    sclk_q <= sclk;
                    cs_q   <= cs_n;
                    mosi_q <= mosi;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sclk_q <= '0;
                    cs_q   <= '1;
                    mosi_q <= '0;
                end else begin
                    sclk_q <= {sclk_q[STAGES-2:0], sclk};
                    cs_q   <= {cs_q[STAGES-2:0], cs_n};
                    mosi_q <= {mosi_q[STAGES-2:0], mosi};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_q[STAGES-1];
    end

    assign sclk_rise = sclk_q[STAGES-1] & ~sclk_prev;
    assign sclk_fall = ~sclk_q[STAGES-1] & sclk_prev;
    assign cs_act    = ~cs_q[STAGES-1];
    assign mosi_s    = mosi_q[STAGES-1];
endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import cfgspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_act,
    input  logic              mosi_s,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              miso,
    output logic              rd_phase
);
    localparam logic [ADDR_W-1:0] ONE_A = 1;

    frame_state_t      state, state_nx;
    logic [3:0]        bit_cnt;
    logic [14:0]       ins_sh;
    logic [6:0]        wsh;
    logic [7:0]        tx;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        byte_idx;
    logic [1:0]        last_idx;
    logic              instr_done;
    logic              byte_done;
    logic              unused_ins_bit;

    assign unused_ins_bit = ins_sh[11];
    assign instr_done = (state == ST_INSTR) && sclk_rise && (bit_cnt == 4'd15);
    assign byte_done  = ((state == ST_WDATA) || (state == ST_RDATA)) &&
                        sclk_rise && (bit_cnt[2:0] == 3'd7);

    always_comb begin
        state_nx = state;
        if (!cs_act) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_INSTR;
                ST_INSTR: if (instr_done) state_nx = ins_sh[14] ? ST_RDATA : ST_WDATA;
                ST_WDATA,
                ST_RDATA: if (byte_done && (byte_idx == last_idx)) state_nx = ST_DONE;
                ST_DONE:  state_nx = ST_DONE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            ins_sh   <= '0;
            wsh      <= '0;
            tx       <= '0;
            addr     <= '0;
            byte_idx <= '0;
            last_idx <= '0;
            wr_stb   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_stb <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    bit_cnt  <= '0;
                    byte_idx <= '0;
                    tx       <= '0;
                end
                ST_INSTR: if (sclk_rise) begin
                    ins_sh  <= {ins_sh[13:0], mosi_s};
                    bit_cnt <= bit_cnt + 4'd1;
                    if (bit_cnt == 4'd15) begin
                        addr     <= {ins_sh[10:0], mosi_s};
                        last_idx <= (ins_sh[13:12] == 2'd3) ? 2'd2 : ins_sh[13:12];
                        bit_cnt  <= '0;
                        byte_idx <= '0;
                    end
                end
                ST_WDATA: if (sclk_rise) begin
                    wsh     <= {wsh[5:0], mosi_s};
                    bit_cnt <= bit_cnt + 4'd1;
                    if (bit_cnt[2:0] == 3'd7) begin
                        wr_stb   <= 1'b1;
                        wr_data  <= {wsh, mosi_s};
                        wr_addr  <= addr;
                        addr     <= addr - ONE_A;
                        byte_idx <= byte_idx + 2'd1;
                        bit_cnt  <= '0;
                    end
                end
                ST_RDATA: begin
                    if (sclk_fall) tx <= (bit_cnt == 4'd0) ? rd_data : {tx[6:0], 1'b0};
                    if (sclk_rise) begin
                        bit_cnt <= bit_cnt + 4'd1;
                        if (bit_cnt[2:0] == 3'd7) begin
                            addr     <= addr - ONE_A;
                            byte_idx <= byte_idx + 2'd1;
                            bit_cnt  <= '0;
                        end
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_phase = (state == ST_RDATA);
        miso     = rd_phase ? tx[7] : 1'b0;
        rd_addr  = addr;
    end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfgspi_pkg::*;
#(
    parameter int                NUM_REGS = 8,
    parameter logic [ADDR_W-1:0] REG_BASE = 12'h010
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_stb,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [7:0]            rd_data,
    output logic                  sdo_en,
    output logic [NUM_REGS*8-1:0] active_regs,
    output logic                  upd_pend,
    output logic                  srst_pend
);
    logic [7:0] shadow [NUM_REGS];
    logic [7:0] active [NUM_REGS];
    logic       rb_sel;

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_BASE + g);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    shadow[g] <= '0;
                    active[g] <= '0;
                end else if (srst_pend) begin
                    shadow[g] <= '0;
                    active[g] <= '0;
                end else begin
                    if (wr_stb && (wr_addr == MY_ADDR)) shadow[g] <= wr_data;
                    if (upd_pend) active[g] <= shadow[g];
                end
            end
            assign active_regs[8*g +: 8] = active[g];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo_en    <= 1'b0;
            rb_sel    <= 1'b0;
            upd_pend  <= 1'b0;
            srst_pend <= 1'b0;
        end else if (srst_pend) begin
            sdo_en    <= 1'b0;
            rb_sel    <= 1'b0;
            upd_pend  <= 1'b0;
            srst_pend <= 1'b0;
        end else begin
            upd_pend <= 1'b0;
            if (wr_stb) begin
                if (wr_addr == ADDR_PORTCFG) begin
                    if (wr_data[BIT_SRST]) srst_pend <= 1'b1;
                    else                   sdo_en    <= wr_data[BIT_SDO_EN];
                end
                if (wr_addr == ADDR_RBSEL)  rb_sel   <= wr_data[BIT_RBSEL];
                if (wr_addr == ADDR_UPDATE) upd_pend <= wr_data[BIT_UPDATE];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_PORTCFG) begin
            rd_data[BIT_SDO_EN] = sdo_en;
            rd_data[BIT_SRST]   = srst_pend;
        end else if (rd_addr == ADDR_RBSEL) begin
            rd_data[BIT_RBSEL] = rb_sel;
        end else if (rd_addr == ADDR_UPDATE) begin
            rd_data[BIT_UPDATE] = upd_pend;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (rd_addr == ADDR_W'(REG_BASE + i)) rd_data = rb_sel ? shadow[i] : active[i];
            end
        end
    end
endmodule

// File: rtl/cfg_spi_port.sv
module cfg_spi_port
    import cfgspi_pkg::*;
#(
    parameter int                NUM_REGS    = 8,
    parameter logic [ADDR_W-1:0] REG_BASE    = 12'h010,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_sclk,
    input  logic                  spi_cs_n,
    input  logic                  spi_mosi,
    output logic                  spi_miso,
    output logic                  sdo_drive,
    output logic                  dio_turn,
    output logic [NUM_REGS*8-1:0] active_regs
);
    logic              sclk_rise, sclk_fall, cs_act, mosi_s;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [7:0]        rd_data, wr_data;
    logic              wr_stb, rd_phase, sdo_en, upd_pend, srst_pend;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .mosi_s    (mosi_s)
    );

    spi_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .mosi_s    (mosi_s),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .miso      (spi_miso),
        .rd_phase  (rd_phase)
    );

    cfg_reg_bank #(.NUM_REGS(NUM_REGS), .REG_BASE(REG_BASE)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .sdo_en      (sdo_en),
        .active_regs (active_regs),
        .upd_pend    (upd_pend),
        .srst_pend   (srst_pend)
    );

    assign sdo_drive = rd_phase & sdo_en;
    assign dio_turn  = rd_phase & ~sdo_en;
endmodule

// File: rtl/cfg_spi_port_chk.sv
module cfg_spi_port_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_stb,
    input logic          cs_act,
    input logic          upd_pend,
    input logic          srst_pend,
    input logic [AW-1:0] active_regs,
    input logic          sdo_drive,
    input logic          dio_turn
);
    p_active_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_pend && !srst_pend) |=> $stable(active_regs));

    p_update_selfclear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pend |=> !upd_pend);

    p_drive_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_drive || dio_turn) |-> cs_act);

    p_one_driver_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sdo_drive, dio_turn}));

    p_srst_defaults_r8: assert property (@(posedge clk) disable iff (!rst_n)
        srst_pend |=> ((active_regs == '0) && !srst_pend));

    p_write_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(cs_act));
endmodule

bind cfg_spi_port cfg_spi_port_chk #(.AW(NUM_REGS*8)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stb      (wr_stb),
    .cs_act      (cs_act),
    .upd_pend    (upd_pend),
    .srst_pend   (srst_pend),
    .active_regs (active_regs),
    .sdo_drive   (sdo_drive),
    .dio_turn    (dio_turn)
);

// File: tb/test_cfg_spi_port.sv
`timescale 1ns/1ps
module test_cfg_spi_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 6;
    localparam int NR = 8;
    localparam int BASE = 16;

    logic clk = 0, rst_n = 0;
    logic spi_sclk = 0, spi_cs_n = 1, spi_mosi = 0;
    logic spi_miso, sdo_drive, dio_turn;
    logic [NR*8-1:0] active_regs;

    int nchk = 0, nerr = 0;
    bit done = 0;

    logic [7:0] m_sh [NR];
    logic [7:0] m_ac [NR];
    logic m_sdo = 0, m_sel = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_spi_port i_cfg_spi_port (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .sdo_drive(sdo_drive),
        .dio_turn(dio_turn), .active_regs(active_regs)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_active();
        logic [63:0] v = '0;
        for (int i = 0; i < NR; i++) v[8*i +: 8] = m_ac[i];
        return v;
    endfunction

    function automatic logic [7:0] exp_read(input logic [11:0] a);
        if (a == 12'h000) return {m_sdo, 7'b0};
        if (a == 12'h004) return {7'b0, m_sel};
        if (a >= 12'(BASE) && a < 12'(BASE + NR))
            return m_sel ? m_sh[int'(a) - BASE] : m_ac[int'(a) - BASE];
        return 8'h00;
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [7:0] d);
        if (a >= 12'(BASE) && a < 12'(BASE + NR)) m_sh[int'(a) - BASE] = d;
        if (a == 12'h000) begin
            if (d[5]) begin
                for (int i = 0; i < NR; i++) begin m_sh[i] = 0; m_ac[i] = 0; end
                m_sdo = 0; m_sel = 0;
            end else m_sdo = d[7];
        end
        if (a == 12'h004) m_sel = d[0];
        if (a == 12'h234 && d[0]) for (int i = 0; i < NR; i++) m_ac[i] = m_sh[i];
    endtask

    task automatic frame(input logic [15:0] ins, input int nb, input logic [31:0] wd,
                         output logic [31:0] rd, output logic [3:0] d4, output logic [3:0] d3);
        rd = 0; d4 = 0; d3 = 0;
        spi_cs_n = 0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < 16 + 8*nb; b++) begin
            if (b < 16) spi_mosi = ins[15-b];
            else        spi_mosi = wd[8*nb-1-(b-16)];
            repeat (HALF) @(negedge clk);
            if (b >= 16) begin
                rd = {rd[30:0], spi_miso};
                if ((b-16) % 8 == 0) begin
                    d4[(b-16)/8] = sdo_drive;
                    d3[(b-16)/8] = dio_turn;
                end
            end
            spi_sclk = 1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 0;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1;
        repeat (4*HALF) @(negedge clk);
    endtask

    task automatic abort_frame(input logic [31:0] stream, input int nbits);
        spi_cs_n = 0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < nbits; b++) begin
            spi_mosi = stream[31-b];
            repeat (HALF) @(negedge clk);
            spi_sclk = 1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 0;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1;
        repeat (4*HALF) @(negedge clk);
    endtask

    function automatic logic [15:0] mk_ins(input bit r, input logic [1:0] code, input logic [11:0] a);
        return {r, code, 1'b0, a};
    endfunction

    task automatic wr(input logic [11:0] a, input int nb, input logic [31:0] wd);
        logic [31:0] rd; logic [3:0] d4, d3;
        frame(mk_ins(0, 2'(nb-1), a), nb, wd, rd, d4, d3);
        for (int j = 0; j < nb; j++) model_write(a - 12'(j), wd[8*(nb-1-j) +: 8]);
    endtask

    task automatic rd1(input logic [11:0] a, output logic [7:0] v, output logic [3:0] d4, output logic [3:0] d3);
        logic [31:0] rd;
        frame(mk_ins(1, 2'd0, a), 1, 32'h0, rd, d4, d3);
        v = rd[7:0];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v; logic [3:0] d4, d3; logic [31:0] rd;
        for (int i = 0; i < NR; i++) begin m_sh[i] = 0; m_ac[i] = 0; end
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);

        // R11 reset state
        chk("R11 active after reset", active_regs, 64'h0);
        chk("R11 drivers idle", {62'h0, sdo_drive, dio_turn}, 64'h0);
        rd1(12'h010, v, d4, d3);
        chk("R11 read reg0", v, 8'h00);
        chk("R7 default 3-wire enables", {d4[0], d3[0]}, 2'b01);

        // R3 shadow writes over all registers
        for (int i = 0; i < NR; i++) begin
            wr(12'(BASE + i), 1, 32'(8'(i*53 + 17)));
            chk("R3 active unchanged by shadow write", active_regs, exp_active());
        end
        // R5 readback select sweep
        for (int i = 0; i < NR; i++) begin
            rd1(12'(BASE + i), v, d4, d3);
            chk("R5 sel0 returns active", v, exp_read(12'(BASE + i)));
        end
        wr(12'h004, 1, 32'h01);
        rd1(12'h004, v, d4, d3);
        chk("R5 select readback", v, 8'h01);
        for (int i = 0; i < NR; i++) begin
            rd1(12'(BASE + i), v, d4, d3);
            chk("R5 sel1 returns shadow", v, exp_read(12'(BASE + i)));
        end

        // R4 update
        wr(12'h234, 1, 32'h01);
        chk("R4 commit to active", active_regs, exp_active());
        rd1(12'h234, v, d4, d3);
        chk("R4 update self-clears", v, 8'h00);
        wr(12'h010, 1, 32'hAA);
        wr(12'h234, 1, 32'hFE);
        chk("R4 bit0 clear commits nothing", active_regs, exp_active());

        // R2 burst order, R1 count field
        wr(12'h017, 3, 32'h112233);
        rd1(12'h017, v, d4, d3); chk("R2 first byte at start", v, 8'h11);
        rd1(12'h016, v, d4, d3); chk("R2 second byte lower", v, 8'h22);
        rd1(12'h015, v, d4, d3); chk("R2 third byte lower", v, 8'h33);
        frame(mk_ins(1, 2'd1, 12'h017), 2, 32'h0, rd, d4, d3);
        chk("R2 two-byte read order", rd[15:0], 16'h1122);
        frame(mk_ins(1, 2'd3, 12'h017), 4, 32'h0, rd, d4, d3);
        chk("R1 code3 serves 3 bytes", rd, 32'h11223300);
        chk("R6 enable for counted bytes only", {d4, d3}, {4'b0000, 4'b0111});
        frame(mk_ins(1, 2'd0, 12'h016), 2, 32'h0, rd, d4, d3);
        chk("R6 one-byte read then idle", rd[15:0], 16'h2200);
        chk("R6 enable one byte", {d4, d3}, {4'b0000, 4'b0001});
        frame({1'b1, 2'b00, 1'b1, 12'h015}, 1, 32'h0, rd, d4, d3);
        chk("R1 bit12 ignored", rd[7:0], 8'h33);

        // R9 aborts
        abort_frame({mk_ins(0, 2'd0, 12'h012), 16'hFFFF}, 21);
        rd1(12'h012, v, d4, d3);
        chk("R9 mid-byte abort discards", v, exp_read(12'h012));
        abort_frame({mk_ins(0, 2'd0, 12'h013), 16'h0}, 10);
        rd1(12'h013, v, d4, d3);
        chk("R9 abort in instruction", v, exp_read(12'h013));
        abort_frame({mk_ins(0, 2'd1, 12'h014), 16'h5A0F}, 28);
        model_write(12'h014, 8'h5A);
        rd1(12'h014, v, d4, d3);
        chk("R9 completed byte kept", v, exp_read(12'h014));
        rd1(12'h013, v, d4, d3);
        chk("R9 partial second byte dropped", v, exp_read(12'h013));

        // R10 unimplemented addresses, full read sweep
        wr(12'h100, 1, 32'hFF);
        wr(12'h3FF, 1, 32'hFF);
        wr(12'h233, 1, 32'hFF);
        chk("R10 active unchanged", active_regs, exp_active());
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 72; a++) begin
                logic [11:0] ad;
                ad = (a < 64) ? 12'(a) : 12'(12'h230 + a - 64);
                rd1(ad, v, d4, d3);
                chk("R10 R5 address sweep", v, exp_read(ad));
            end
            wr(12'h004, 1, 32'h00);
        end

        // R7 4-wire
        wr(12'h000, 1, 32'h80);
        rd1(12'h000, v, d4, d3);
        chk("R7 read port config", v, 8'h80);
        chk("R7 4-wire enables", {d4[0], d3[0]}, 2'b10);

        // R8 soft reset
        wr(12'h004, 1, 32'h01);
        wr(12'h000, 1, 32'hA0);
        chk("R8 active to defaults", active_regs, 64'h0);
        rd1(12'h000, v, d4, d3);
        chk("R8 port config cleared", v, 8'h00);
        chk("R8 back to 3-wire", {d4[0], d3[0]}, 2'b01);
        rd1(12'h004, v, d4, d3);
        chk("R8 select cleared", v, 8'h00);
        wr(12'h004, 1, 32'h01);
        for (int i = 0; i < NR; i++) begin
            rd1(12'(BASE + i), v, d4, d3);
            chk("R8 shadow cleared", v, 8'h00);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule